// File: doc/BRIEF.md
# Masked-Write GPIO Port Register File

This block is a 32-pin general-purpose I/O port controlled through a small 32-bit register bus made of an address, a write enable, write data and registered read data. Software never needs a read-modify-write sequence to change it. A pin becomes an output when a 1 is written to its bit in a set strobe register. It returns to input when a 1 is written to its bit in a clear strobe register. The output level of each pin sits in a 32-bit latch. That latch is updated through two half-word registers, and each of them carries a per-bit write mask in its upper 16 bits.

The pad side is modelled as three separate vectors: output data, output enable and input level. The input levels pass through a two-stage synchronizer before they can be read back. The output latch keeps its value while a pin is an input, so a level prepared in advance is driven as soon as the pin is switched to output. Interrupt detection, pin multiplexing and the bus fabric belong to neighbouring blocks.

Top module: `gpio_port_regs`

## Requirements
- R1: While reset is high and on the first cycle after it, pad_oe, pad_out and reg_rdata are all zero (all pins inputs, latch cleared).
- R2: A write to offset 0x00 sets pad_oe[i] for every bit i that is 1 in the write data, from the clock edge that takes the write. Bits written 0 keep their previous direction.
- R3: A write to offset 0x04 clears pad_oe[i] for every bit i that is 1 in the write data. Bits written 0 keep their previous direction.
- R4: A write to offset 0x08 updates pad_out[i] for i in 0..15 to write data bit i, but only where write data bit 16+i is 1. Every other latch bit is unchanged.
- R5: A write to offset 0x0C updates pad_out[16+i] for i in 0..15 to write data bit i, but only where write data bit 16+i is 1. Every other latch bit is unchanged.
- R6: The output latch holds values written while a pin is an input. Once pad_oe for that pin is set, pad_out already shows the stored value.
- R7: A read of offset 0x10 returns pad_in as it was sampled through two flops. A pin change made before edge k is returned on reg_rdata after edge k+2.
- R8: A read of 0x04 returns the output-enable vector. Reads of 0x08 and 0x0C return the low and high latched halves in bits 15:0 with zeros above. A read of 0x00 returns zero.
- R9: Any other offset, including 0x10 for writes, ignores writes and reads as zero.
- R10: reg_rdata is registered. It shows the addressed value as it was just before the edge that follows the cycle in which the address was presented.

Top module port order is listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Byte offset of the register accessed |
| reg_we | input | 1 | Write enable for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data, one cycle after the address |
| pad_in | input | 32 | Asynchronous pin input levels |
| pad_out | output | 32 | Output data driven to the pads |
| pad_oe | output | 32 | Per-pin output enable |

## Verification
The bench builds the block with its default parameters: 32-bit data split into two 16-bit masked halves, an 8-bit address and a two-stage synchronizer. With an 8-bit address, unmapped offsets such as 0x02, 0x14 and 0xFC can be reached, and the exact three-edge latency of a pin change through the synchronizer can be observed. A behavioural model updates the direction, the latch and a queue of input samples on each edge, and it is compared with all three outputs on every cycle. Directed sequences with hand-computed constants cover partial masks, all-zero masks and a latch value written ahead of its direction change. A random phase then mixes writes across all offsets.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;

  localparam logic [7:0] OFS_DIR_SET = 8'h00;
  localparam logic [7:0] OFS_DIR_CLR = 8'h04;
  localparam logic [7:0] OFS_OUT_LO  = 8'h08;
  localparam logic [7:0] OFS_OUT_HI  = 8'h0C;
  localparam logic [7:0] OFS_PIN_IN  = 8'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DIR_SET,
    SEL_DIR_CLR,
    SEL_OUT_LO,
    SEL_OUT_HI,
    SEL_PIN_IN
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
    case (ofs)
      OFS_DIR_SET: decode_ofs = SEL_DIR_SET;
      OFS_DIR_CLR: decode_ofs = SEL_DIR_CLR;
      OFS_OUT_LO:  decode_ofs = SEL_OUT_LO;
      OFS_OUT_HI:  decode_ofs = SEL_OUT_HI;
      OFS_PIN_IN:  decode_ofs = SEL_PIN_IN;
      default:     decode_ofs = SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_dir_ctl.sv
module gpio_dir_ctl #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_stb,
  input  logic             clr_stb,
  input  logic [WIDTH-1:0] bit_sel,
  output logic [WIDTH-1:0] oe_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q <= '0;
    end else if (set_stb) begin
      oe_q <= oe_q | bit_sel;
    end else if (clr_stb) begin
      oe_q <= oe_q & ~bit_sel;
    end
  end

  AST_DIR_SET_BITS: assert property (@(posedge clk) disable iff (rst)
    set_stb |=> ((oe_q & $past(bit_sel)) == $past(bit_sel))); // R2

  AST_DIR_CLR_BITS: assert property (@(posedge clk) disable iff (rst)
    clr_stb |=> ((oe_q & $past(bit_sel)) == '0)); // R3

  AST_DIR_SET_KEEPS: assert property (@(posedge clk) disable iff (rst)
    set_stb |=> ((oe_q & ~$past(bit_sel)) == ($past(oe_q) & ~$past(bit_sel)))); // R2

  AST_DIR_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!set_stb && !clr_stb) |=> $stable(oe_q)); // R3

endmodule

// File: rtl/gpio_out_half.sv
module gpio_out_half #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [HALF_W-1:0] wr_mask,
  input  logic [HALF_W-1:0] wr_val,
  output logic [HALF_W-1:0] lat_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q <= '0;
    end else if (wr_stb) begin
      lat_q <= (lat_q & ~wr_mask) | (wr_val & wr_mask);
    end
  end

  AST_MASKED_BITS_HOLD: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> (((lat_q ^ $past(lat_q)) & ~$past(wr_mask)) == '0)); // R4

  AST_UNMASKED_TAKE: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> ((lat_q & $past(wr_mask)) == ($past(wr_val) & $past(wr_mask)))); // R5

  AST_LATCH_IDLE: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> $stable(lat_q)); // R6

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign sync_out = stg[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_regs_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] pad_in,
  output logic [DATA_W-1:0] pad_out,
  output logic [DATA_W-1:0] pad_oe
);

  localparam int HALF_W = DATA_W / 2;
  localparam int N_HALF = 2;

  reg_sel_e          sel;
  logic [DATA_W-1:0] oe_q;
  logic [DATA_W-1:0] pin_sync;
  logic [HALF_W-1:0] half_q [N_HALF];
  logic [DATA_W-1:0] rd_next;

  assign sel = decode_ofs(8'(reg_addr));

  gpio_dir_ctl #(.WIDTH(DATA_W)) u_dir (
    .clk     (clk),
    .rst     (rst),
    .set_stb (reg_we && (sel == SEL_DIR_SET)),
    .clr_stb (reg_we && (sel == SEL_DIR_CLR)),
    .bit_sel (reg_wdata),
    .oe_q    (oe_q)
  );

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    localparam reg_sel_e HSEL = (h == 0) ? SEL_OUT_LO : SEL_OUT_HI;
    gpio_out_half #(.HALF_W(HALF_W)) u_half (
      .clk     (clk),
      .rst     (rst),
      .wr_stb  (reg_we && (sel == HSEL)),
      .wr_mask (reg_wdata[DATA_W-1:HALF_W]),
      .wr_val  (reg_wdata[HALF_W-1:0]),
      .lat_q   (half_q[h])
    );
    assign pad_out[h*HALF_W +: HALF_W] = half_q[h];
  end

  gpio_in_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pad_in),
    .sync_out (pin_sync)
  );

  assign pad_oe = oe_q;

  always_comb begin
    rd_next = '0;
    case (sel)
      SEL_DIR_CLR: rd_next = oe_q;
      SEL_OUT_LO:  rd_next[HALF_W-1:0] = half_q[0];
      SEL_OUT_HI:  rd_next[HALF_W-1:0] = half_q[1];
      SEL_PIN_IN:  rd_next = pin_sync;
      default:     rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((sel == SEL_NONE) || (sel == SEL_DIR_SET)) |=> (reg_rdata == '0)); // R9

  AST_OE_READBACK: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_DIR_CLR) |=> (reg_rdata == $past(pad_oe))); // R8

  AST_HALF_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((sel == SEL_OUT_LO) || (sel == SEL_OUT_HI)) |=> (reg_rdata[DATA_W-1:HALF_W] == '0)); // R8

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> ((pad_oe == '0) && (pad_out == '0) && (reg_rdata == '0))); // R1

endmodule

// File: tb/test_gpio_port_regs.sv
module test_gpio_port_regs;

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [31:0] pad_in;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  string tag   = "R1";
  bit model_on = 1'b0;

  always #2.5 clk = ~clk;

  gpio_port_regs i_gpio_port_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
  );

  // behavioural reference model
  logic [31:0] m_oe, m_out, m_rd;
  logic [31:0] m_pipe [$];

  always @(posedge clk) begin
    logic [31:0] nrd;
    if (rst) begin
      m_oe = 0; m_out = 0; m_rd = 0;
      m_pipe.delete();
      m_pipe.push_back(32'h0);
      m_pipe.push_back(32'h0);
    end else begin
      case (reg_addr)
        8'h04:   nrd = m_oe;
        8'h08:   nrd = {16'h0, m_out[15:0]};
        8'h0C:   nrd = {16'h0, m_out[31:16]};
        8'h10:   nrd = m_pipe[0];
        default: nrd = 0;
      endcase
      if (reg_we) begin
        case (reg_addr)
          8'h00: m_oe = m_oe | reg_wdata;
          8'h04: m_oe = m_oe & ~reg_wdata;
          8'h08: for (int i = 0; i < 16; i++) if (reg_wdata[16+i]) m_out[i] = reg_wdata[i];
          8'h0C: for (int i = 0; i < 16; i++) if (reg_wdata[16+i]) m_out[16+i] = reg_wdata[i];
          default: ;
        endcase
      end
      m_pipe.push_back(pad_in);
      void'(m_pipe.pop_front());
      m_rd = nrd;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got %h expected %h", req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (model_on) begin
      chk(tag, "model pad_oe", pad_oe, m_oe);
      chk(tag, "model pad_out", pad_out, m_out);
      chk(tag, "model reg_rdata", reg_rdata, m_rd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 8'hF0; reg_wdata = 32'h0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    reg_addr = a; reg_we = 1'b0;
    @(negedge clk);
    v = reg_rdata;
    reg_addr = 8'hF0;
  endtask

  initial begin
    logic [31:0] v;
    rst = 1'b1; reg_addr = 8'hF0; reg_we = 1'b0; reg_wdata = 0; pad_in = 0;
    repeat (3) @(negedge clk);
    chk("R1", "pad_oe in reset", pad_oe, 32'h0);
    chk("R1", "pad_out in reset", pad_out, 32'h0);
    chk("R1", "rdata in reset", reg_rdata, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    model_on = 1'b1;
    chk("R1", "pad_oe after reset", pad_oe, 32'h0);

    tag = "R2";
    wr(8'h00, 32'hA5A5_0F0F);
    chk("R2", "set strobe", pad_oe, 32'hA5A5_0F0F);
    wr(8'h00, 32'h0000_00F0);
    chk("R2", "set keeps others", pad_oe, 32'hA5A5_0FFF);

    tag = "R3";
    wr(8'h04, 32'h0000_0F0F);
    chk("R3", "clear strobe", pad_oe, 32'hA5A5_00F0);

    tag = "R8";
    rd(8'h04, v);
    chk("R8", "oe readback", v, 32'hA5A5_00F0);
    rd(8'h00, v);
    chk("R8", "set register reads zero", v, 32'h0);

    tag = "R4";
    wr(8'h08, 32'h00FF_1234);
    chk("R4", "low half partial mask", pad_out, 32'h0000_0034);
    wr(8'h08, 32'hFF00_ABCD);
    chk("R4", "low half upper byte", pad_out, 32'h0000_AB34);

    tag = "R5";
    wr(8'h0C, 32'hFFFF_5A5A);
    chk("R5", "high half full mask", pad_out, 32'h5A5A_AB34);
    wr(8'h0C, 32'h0000_FFFF);
    chk("R5", "high half zero mask", pad_out, 32'h5A5A_AB34);

    tag = "R8";
    rd(8'h08, v);
    chk("R8", "low half readback", v, 32'h0000_AB34);
    rd(8'h0C, v);
    chk("R8", "high half readback", v, 32'h0000_5A5A);

    tag = "R6";
    wr(8'h04, 32'hFFFF_FFFF);
    chk("R6", "all inputs", pad_oe, 32'h0);
    wr(8'h08, 32'h0001_0001);
    chk("R6", "latch written while input", pad_out, 32'h5A5A_AB35);
    wr(8'h00, 32'h0000_0001);
    chk("R6", "oe now set", pad_oe, 32'h0000_0001);
    chk("R6", "held value driven", pad_out, 32'h5A5A_AB35);

    tag = "R7";
    pad_in = 32'hDEAD_BEEF;
    reg_addr = 8'h10;
    @(negedge clk);
    chk("R7", "edge 1 still old", reg_rdata, 32'h0);
    @(negedge clk);
    chk("R7", "edge 2 still old", reg_rdata, 32'h0);
    @(negedge clk);
    chk("R10", "edge 3 shows new input", reg_rdata, 32'hDEAD_BEEF);
    reg_addr = 8'hF0;

    tag = "R9";
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    wr(8'h02, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    chk("R9", "oe untouched", pad_oe, 32'h0000_0001);
    chk("R9", "latch untouched", pad_out, 32'h5A5A_AB35);
    rd(8'h14, v);
    chk("R9", "unmapped 0x14 reads zero", v, 32'h0);
    rd(8'h02, v);
    chk("R9", "unmapped 0x02 reads zero", v, 32'h0);

    tag = "R10";
    for (int k = 0; k < 400; k++) begin
      logic [7:0] a;
      case ($urandom_range(0, 6))
        0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h0C;
        4: a = 8'h10; 5: a = 8'h14; default: a = 8'($urandom);
      endcase
      pad_in = $urandom;
      reg_addr = a; reg_we = 1'($urandom); reg_wdata = $urandom;
      @(negedge clk);
    end
    reg_we = 1'b0;
    @(negedge clk);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule